// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for a software heartbeat. A counter advances on every pulse of a slow timebase tick, which comes from the always-running low-speed clock domain. Because of this the counter keeps running while the fast system clock is gated. Nothing in the block can stop the counter. Software restarts it with a two-write unlock sequence on a byte-wide write port. One of four timeout lengths is chosen by a two-bit period code.

If the timeout elapses, the block raises a one-cycle non-maskable interrupt request. Software can then still recover. If the timeout elapses again with no valid clear in between, the block raises a system reset request. That request holds until the block itself is reset. A valid clear restarts the counter and drops the escalation back to the first stage.

At the default parameter setting the periods are 4096, 16384, 65536 and 262144 ticks. With a 32.768 kHz tick these give 125 ms, 500 ms, 2 s and 8 s. All inputs are plain control pins with no handshake: a write is taken in any cycle where its enable is high.

Top module: `wdog_escal`

## Requirements
- R1: After reset `nmi_req` and `rst_req` are low, the active period code is 0, and the unlock sequence is idle.
- R2: The first overflow after reset or after a valid clear drives `nmi_req` high for exactly one clock cycle. It leaves `rst_req` low.
- R3: An overflow that occurs while the first-stage flag is set raises `rst_req`. `rst_req` then stays high, even across clears, until `rst_n` is asserted.
- R4: The period is 2^(BASE_SHIFT + 2*code) ticks, where code is the 2-bit active period code 0..3. Larger codes give longer periods. Overflow is flagged on the tick that completes the period, and the request outputs change at the clock edge of that tick.
- R5: The counter advances only in cycles with `tick` high. Cycles without `tick` change neither the count nor the outputs.
- R6: A clear happens only when a write of KEY_B (default 0xA5) directly follows a write of KEY_A (default 0x5A) among `key_we` writes. Idle cycles between the two writes are allowed. A write of any other value cancels a pending KEY_A. A repeated KEY_A keeps the sequence armed.
- R7: A valid clear sets the count to zero and clears the first-stage flag, so the next overflow produces only an NMI request.
- R8: A write on `period_we` only stores a pending code. The active period takes the pending code at the next valid clear. A period write in the same cycle as the clear is included.
- R9: When a valid clear and the overflowing tick fall in the same cycle, the clear wins: no NMI, no reset, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase pulse from the low-speed clock |
| key_we | input | 1 | Unlock-byte write strobe |
| key_data | input | 8 | Unlock byte |
| period_we | input | 1 | Period code write strobe |
| period_sel | input | 2 | Period code, 0 shortest to 3 longest |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The overflowing tick and the completing KEY_B write can occur in the same cycle. The bench provokes this on purpose: it runs the count to one tick short of the period, writes KEY_A in a cycle with no tick, and then writes KEY_B together with the tick that would overflow. The outputs are judged a cycle later: neither request may appear, and a full fresh period must pass before the next NMI request. The random phase also produces this collision at times. There, every cycle is compared against a bench model that gives the clear priority.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef logic [1:0] per_code_t;
  localparam int unsigned NUM_PERIODS = 4;

  // Ticks in one period: each code step multiplies by four.
  function automatic int unsigned period_len(input int unsigned base_shift,
                                             input int unsigned code);
    return 32'd1 << (base_shift + 2 * code);
  endfunction
endpackage

// File: rtl/wdog_key.sv
module wdog_key #(
  parameter logic [7:0] KEY_A = 8'h5A,
  parameter logic [7:0] KEY_B = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       clr
);
  logic armed_q;

  assign clr = wr_en && (wr_data == KEY_B) && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= (wr_data == KEY_A);
  end

  // R6
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != KEY_A) |=> !armed_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      clr,
  input  logic      per_we,
  input  per_code_t per_in,
  output logic      ovf
);
  localparam int unsigned CW = BASE_SHIFT + 2 * (NUM_PERIODS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_tab [NUM_PERIODS];
  per_code_t     pend_q, act_q, pend_nx;
  logic          at_end;

  genvar g;
  generate
    for (g = 0; g < NUM_PERIODS; g++) begin : g_lim
      assign last_tab[g] = CW'(period_len(BASE_SHIFT, g) - 1);
    end
  endgenerate

  assign pend_nx = per_we ? per_in : pend_q;
  assign at_end  = (cnt_q == last_tab[act_q]);
  assign ovf     = tick && !clr && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_nx;
      if (clr) begin
        cnt_q <= '0;
        act_q <= pend_nx;
      end else if (tick) begin
        cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(act_q));
endmodule

// File: rtl/wdog_escal.sv
module wdog_escal
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 12,
  parameter logic [7:0]  KEY_A      = 8'h5A,
  parameter logic [7:0]  KEY_B      = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       key_we,
  input  logic [7:0] key_data,
  input  logic       period_we,
  input  logic [1:0] period_sel,
  output logic       nmi_req,
  output logic       rst_req
);
  logic clr, ovf, stage_q;

  wdog_key #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(key_we), .wr_data(key_data), .clr(clr)
  );

  wdog_counter #(.BASE_SHIFT(BASE_SHIFT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr),
    .per_we(period_we), .per_in(per_code_t'(period_sel)), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      nmi_req <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      nmi_req <= ovf && !stage_q;
      if (clr)      stage_q <= 1'b0;
      else if (ovf) stage_q <= 1'b1;
      if (ovf && stage_q) rst_req <= 1'b1;
    end
  end

  // R2
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);
  // R2
  nmi_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> !$rose(rst_req));
  // R3
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
endmodule

// File: tb/wdog_escal_bench.sv
module wdog_escal_bench;
  localparam int unsigned BS = 3;
  localparam logic [7:0] KA = 8'h5A, KB = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, key_we = 1'b0, period_we = 1'b0;
  logic [7:0] key_data = '0;
  logic [1:0] period_sel = '0;
  logic nmi_req, rst_req;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  int unsigned m_cnt;
  bit m_armed, m_stage, m_nmi, m_rst;
  int unsigned m_act, m_pend;

  always #2.5 clk = ~clk;

  wdog_escal #(.BASE_SHIFT(BS), .KEY_A(KA), .KEY_B(KB)) u_wdog_escal (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key_we(key_we), .key_data(key_data),
    .period_we(period_we), .period_sel(period_sel), .nmi_req(nmi_req), .rst_req(rst_req)
  );

  function automatic int unsigned plen(input int unsigned code);
    return 1 << (BS + 2 * code);
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_armed = 0; m_stage = 0; m_nmi = 0; m_rst = 0; m_act = 0; m_pend = 0;
  endtask

  task automatic model_step(input bit t, input bit we, input logic [7:0] d,
                            input bit pwe, input logic [1:0] ps);
    bit clr;
    clr = we && d == KB && m_armed;
    if (we) m_armed = (d == KA);
    if (pwe) m_pend = ps;
    m_nmi = 0;
    if (clr) begin
      m_cnt = 0; m_stage = 0; m_act = m_pend;
    end else if (t) begin
      if (m_cnt == plen(m_act) - 1) begin
        m_cnt = 0;
        if (!m_stage) begin m_nmi = 1; m_stage = 1; end
        else m_rst = 1;
      end else m_cnt++;
    end
  endtask

  // drive at negedge, let one edge pass, compare at the next negedge
  task automatic step(input string req, input bit t, input bit we, input logic [7:0] d,
                      input bit pwe, input logic [1:0] ps);
    tick = t; key_we = we; key_data = d; period_we = pwe; period_sel = ps;
    model_step(t, we, d, pwe, ps);
    @(posedge clk); @(negedge clk);
    chk({req, " nmi"}, nmi_req, m_nmi);
    chk({req, " rst"}, rst_req, m_rst);
  endtask

  task automatic idle(input string req, input int n, input bit t);
    for (int i = 0; i < n; i++) step(req, t, 0, 8'h00, 0, 2'd0);
  endtask

  task automatic kick(input string req);
    step(req, 0, 1, KA, 0, 2'd0);
    step(req, 0, 1, KB, 0, 2'd0);
  endtask

  task automatic do_reset();
    tick = 0; key_we = 0; period_we = 0;
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();
    // R1: quiet outputs after reset
    chk("R1 nmi", nmi_req, 1'b0);
    chk("R1 rst", rst_req, 1'b0);

    // R4 / R2: shortest period, one tick per cycle
    idle("R4", plen(0) - 1, 1);
    step("R4 R2 first overflow", 1, 0, 8'h00, 0, 2'd0);
    chk("R2 pulse high", nmi_req, 1'b1);
    step("R2 pulse end", 0, 0, 8'h00, 0, 2'd0);
    // R3: second overflow then sticky through a clear
    idle("R3", plen(0), 1);
    chk("R3 reset request", rst_req, 1'b1);
    kick("R3 clear ignored");
    idle("R3 sticky", 20, 1);
    chk("R3 still high", rst_req, 1'b1);

    // R5: no ticks, nothing moves
    do_reset();
    idle("R5 no tick", 60, 0);
    idle("R5 ticks", plen(0), 1);

    // R8 / R7: period write pending until clear; clear rearms first stage
    do_reset();
    step("R8 write", 0, 0, 8'h00, 1, 2'd1);
    idle("R8 old period", plen(0), 1);
    kick("R7 clear after nmi");
    idle("R8 new period", plen(1), 1);
    chk("R7 nmi again not reset", rst_req, 1'b0);
    step("R8 same-cycle write", 0, 1, KA, 0, 2'd0);
    step("R8 same-cycle write", 0, 1, KB, 1, 2'd3);
    idle("R4 longest", plen(3) + 2, 1);

    // R6: broken and repeated sequences
    do_reset();
    step("R6", 0, 1, KA, 0, 2'd0);
    step("R6 break", 0, 1, 8'h33, 0, 2'd0);
    step("R6 B alone", 1, 1, KB, 0, 2'd0);
    step("R6 AA", 0, 1, KA, 0, 2'd0);
    step("R6 AA", 0, 1, KA, 0, 2'd0);
    idle("R6 gap", 3, 0);
    step("R6 AAB", 0, 1, KB, 0, 2'd0);
    idle("R6 after", plen(0) + 1, 1);

    // R9: clear on the overflowing tick
    do_reset();
    idle("R9", plen(0) - 1, 1);
    step("R9 arm", 0, 1, KA, 0, 2'd0);
    step("R9 collide", 1, 1, KB, 0, 2'd0);
    chk("R9 no nmi", nmi_req, 1'b0);
    idle("R9 fresh period", plen(0), 1);

    // random phase, all of R2 R3 R4 R5 R6 R7 R8 R9 against the model
    for (int i = 0; i < 6000; i++) begin
      int unsigned r;
      bit t, we, pwe;
      logic [7:0] d;
      if (m_rst && ($urandom % 8 == 0)) do_reset();
      t = ($urandom % 2) == 0;
      r = $urandom % 16;
      we = (r < 5);
      d = (r < 2) ? KA : (r < 4) ? KB : 8'($urandom);
      pwe = ($urandom % 32) == 0;
      step("R2 R3 random", t, we, d, pwe, 2'($urandom % 3));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule